// File: doc/BRIEF.md
# Per-Queue Condition Interrupt Controller

This block turns the live fill flags of a bank of hardware queues into interrupt requests. It keeps one latched status bit per queue. Each queue has a 3-bit selector that picks one of eight conditions: a fill flag (empty, nearly empty, nearly full, full) or the inverse of that flag. A status bit is latched when its queue's selected condition becomes true. Software clears status bits by writing ones to them. A per-queue enable mask decides which latched bits reach the single combined interrupt line.

The queue manager drives the four flag vectors, with one bit per queue. A simple register port sets up the selectors and the enable mask and services the status word. Reads are combinational from the address. Writes take effect at the clock edge where `reg_we` is high.

Top module: `qcond_irq_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, every selector, enable and status bit reads 0 and `irq` is low.
- R2: Register map, with 32-bit words. Addresses 0 to 3 hold the selectors. Queue q sits in word q/8 at bits [4*(q%8)+2 : 4*(q%8)]. Bit 4*(q%8)+3 of each slot is reserved: it reads 0 and ignores writes. Address 4 is the enable mask, with bit q for queue q. Address 5 is the status word, with bit q for queue q. Addresses 6 and 7 read 0, and writes to them change nothing.
- R3: The selector codes are 0 = empty, 1 = nearly empty, 2 = nearly full and 3 = full. Codes 4 to 7 select the inverse of codes 0 to 3 in the same order.
- R4: A status bit is set at the clock edge where its queue's selected condition is true and was false at the previous edge. This holds whatever the enable bit is. A rise caused by a selector write counts. The first edge after reset never sets a bit.
- R5: A status bit that is set stays set while its condition stays true, and also when the condition falls. Only a clear write removes it.
- R6: Writing address 5 clears every status bit whose write-data bit is 1 and leaves the other bits unchanged. Writing all ones clears the whole word.
- R7: `irq` is high in the same cycle as the register state exactly when some status bit and its enable bit are both 1.
- R8: If a condition rise and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R9: Writing ones to status bits that are 0 does not set them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_empty | input | NQ | Per-queue empty flag |
| q_near_empty | input | NQ | Per-queue nearly-empty flag |
| q_near_full | input | NQ | Per-queue nearly-full flag |
| q_full | input | NQ | Per-queue full flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
A selector stored wrongly, or decoded wrongly, shows up in the selector readback at once. It also makes the status word differ from the expected value at the first edge where the affected queue's flags move. A wrong previous-condition state either produces a spurious status bit or misses an edge. The status read that follows that edge exposes it. A bad enable mask or OR tree shows on `irq` in the same cycle as the status change. The sweep gives every queue a code and drives shifted flag patterns, so each of the eight codes is exercised on several queues.

// File: rtl/qcond_irq_ctrl.sv
module qcond_irq_ctrl #(
  parameter int NQ = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] q_empty,
  input  logic [NQ-1:0] q_near_empty,
  input  logic [NQ-1:0] q_near_full,
  input  logic [NQ-1:0] q_full,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq
);
  localparam int NW      = NQ / 8;
  localparam int ADDR_EN = NW;
  localparam int ADDR_ST = NW + 1;

  logic [2:0]    sel [NQ];
  logic [31:0]   sel_word [NW];
  logic [NQ-1:0] en_r, stat_r, cond, cond_q, rise, clr;

  genvar q;
  generate
    for (q = 0; q < NQ; q++) begin : g_q
      logic flag;
      always_comb begin
        case (sel[q][1:0])
          2'd0:    flag = q_empty[q];
          2'd1:    flag = q_near_empty[q];
          2'd2:    flag = q_near_full[q];
          default: flag = q_full[q];
        endcase
      end
      assign cond[q] = flag ^ sel[q][2];

      always_ff @(posedge clk) begin
        if (!rst_n)
          sel[q] <= 3'd0;
        else if (reg_we && reg_addr == AW'(q / 8))
          sel[q] <= reg_wdata[4*(q%8) +: 3];
      end

      assign sel_word[q/8][4*(q%8) +: 4] = {1'b0, sel[q]};
    end
  endgenerate

  assign rise = cond & ~cond_q;
  assign clr  = (reg_we && reg_addr == AW'(ADDR_ST)) ? reg_wdata[NQ-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_r   <= '0;
      stat_r <= '0;
      cond_q <= '1;
    end else begin
      if (reg_we && reg_addr == AW'(ADDR_EN))
        en_r <= reg_wdata[NQ-1:0];
      stat_r <= (stat_r & ~clr) | rise;
      cond_q <= cond;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < NW; w++)
      if (reg_addr == AW'(w)) reg_rdata = sel_word[w];
    if (reg_addr == AW'(ADDR_EN)) reg_rdata = 32'(en_r);
    if (reg_addr == AW'(ADDR_ST)) reg_rdata = 32'(stat_r);
  end

  assign irq = |(stat_r & en_r);
endmodule

module qcond_irq_ctrl_chk #(
  parameter int NQ = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          irq,
  input logic [NQ-1:0] en_r,
  input logic [NQ-1:0] stat_r,
  input logic [NQ-1:0] cond,
  input logic [NQ-1:0] cond_q
);
  localparam int ADDR_ST = NQ / 8 + 1;
  logic clr_wr;
  assign clr_wr = reg_we && reg_addr == AW'(ADDR_ST);

  genvar i;
  generate
    for (i = 0; i < NQ; i++) begin : g_a
      a_r4_set_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        cond[i] && !cond_q[i] |=> stat_r[i]);
      a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && reg_wdata[i] && cond[i] && !cond_q[i] |=> stat_r[i]);
      a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && reg_wdata[i] && !(cond[i] && !cond_q[i]) |=> !stat_r[i]);
      a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_r[i] && !(cond[i] && !cond_q[i]) |=> !stat_r[i]);
      a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stat_r[i] && !(clr_wr && reg_wdata[i]) |=> stat_r[i]);
    end
  endgenerate

  a_r7_no_status_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    stat_r == '0 |-> !irq);
  a_r7_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    en_r == '0 |-> !irq);
endmodule

bind qcond_irq_ctrl qcond_irq_ctrl_chk #(.NQ(NQ), .AW(AW)) u_chk (.*);

// File: tb/qcond_irq_ctrl_test.sv
`timescale 1ns/100ps
module qcond_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] q_empty = '0, q_near_empty = '0, q_near_full = '0, q_full = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  qcond_irq_ctrl uut (.clk, .rst_n, .q_empty, .q_near_empty, .q_near_full, .q_full,
                      .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .irq);

  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit [2:0]  msel [32];
  bit [31:0] men, mstat, mprev;
  bit [31:0] fe, fn, ff, fu;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit mcond(int q);
    bit f;
    case (msel[q][1:0])
      2'd0: f = fe[q];
      2'd1: f = fn[q];
      2'd2: f = ff[q];
      default: f = fu[q];
    endcase
    return f ^ msel[q][2];
  endfunction

  task automatic step(bit we, bit [2:0] a, bit [31:0] d);
    bit [31:0] c, clr;
    reg_we = we; reg_addr = a; reg_wdata = d;
    q_empty = fe; q_near_empty = fn; q_near_full = ff; q_full = fu;
    @(posedge clk);
    for (int q = 0; q < 32; q++) c[q] = mcond(q);
    clr = (we && a == 3'd5) ? d : '0;
    mstat = (mstat & ~clr) | (c & ~mprev);
    mprev = c;
    if (we && a < 3'd4)
      for (int k = 0; k < 8; k++) msel[a*8+k] = d[4*k +: 3];
    if (we && a == 3'd4) men = d;
    #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(bit [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic check_state(string tag);
    logic [31:0] v;
    rd(3'd5, v);
    chk({tag, " status"}, v, mstat);
    chk("R7 irq", 32'(irq), 32'(|(mstat & men)));
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset register", v, 32'h0);
    end
    chk("R1 reset irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    mprev = '1; mstat = '0; men = '0;
    for (int q = 0; q < 32; q++) msel[q] = '0;
    step(0, 3'd0, 0);
    check_state("R1");

    // R2: reserved slot bits read zero
    for (int w = 0; w < 4; w++) step(1, 3'(w), 32'hFFFF_FFFF);
    for (int w = 0; w < 4; w++) begin
      rd(3'(w), v);
      chk("R2 reserved bits", v, 32'h7777_7777);
    end
    // R3: queue q gets code q%8
    for (int w = 0; w < 4; w++) step(1, 3'(w), 32'h7654_3210);
    step(1, 3'd6, 32'hFFFF_FFFF);
    step(1, 3'd7, 32'hFFFF_FFFF);
    for (int w = 0; w < 4; w++) begin
      rd(3'(w), v);
      chk("R2 selector readback", v, 32'h7654_3210);
    end
    rd(3'd6, v); chk("R2 unused addr 6", v, 0);
    rd(3'd7, v); chk("R2 unused addr 7", v, 0);
    step(1, 3'd5, 32'hFFFF_FFFF);
    check_state("R2");
    step(1, 3'd4, 32'hA5A5_5A5A);
    rd(3'd4, v); chk("R2 enable readback", v, 32'hA5A5_5A5A);

    // R3/R4 sweep over shifted flag patterns
    for (int s = 0; s < 64; s++) begin
      for (int q = 0; q < 32; q++) begin
        int p;
        p = (s + q * 3) % 16;
        fe[q] = p[0]; fn[q] = p[1]; ff[q] = p[2]; fu[q] = p[3];
      end
      if (s % 8 == 7) begin
        step(1, 3'd5, 32'h0F0F_F0F0);
        check_state("R6");
      end else begin
        step(0, 3'd0, 0);
        check_state("R3 R4");
      end
    end

    step(1, 3'd5, 32'hFFFF_FFFF);
    check_state("R6");
    chk("R6 clear all", mstat, 32'h0);

    // R8: rise and clear in the same cycle
    for (int w = 0; w < 4; w++) step(1, 3'(w), 32'h0);
    fe = '0;
    step(0, 3'd0, 0);
    step(1, 3'd5, 32'hFFFF_FFFF);
    check_state("R6");
    fe = '1;
    step(1, 3'd5, 32'hFFFF_FFFF);
    rd(3'd5, v);
    chk("R8 set wins", v, 32'hFFFF_FFFF);
    check_state("R8");

    // R5: stays set while true and after the condition falls
    step(0, 3'd0, 0);
    check_state("R5");
    fe = '0;
    step(0, 3'd0, 0);
    rd(3'd5, v);
    chk("R5 sticky after fall", v, 32'hFFFF_FFFF);

    // R7: enable masking
    step(1, 3'd4, 32'h0);
    chk("R7 all disabled", 32'(irq), 0);
    step(1, 3'd4, 32'h0000_0100);
    chk("R7 one enabled", 32'(irq), 1);

    // R9: writing ones to cleared bits sets nothing
    step(1, 3'd5, 32'hFFFF_FFFF);
    step(1, 3'd5, 32'hFFFF_FFFF);
    rd(3'd5, v);
    chk("R9 no set by write", v, 32'h0);

    // R4: a selector change that makes the condition rise
    fe = '1;
    for (int w = 0; w < 4; w++) step(1, 3'(w), 32'h4444_4444);
    step(1, 3'd5, 32'hFFFF_FFFF);
    check_state("R4");
    step(1, 3'd1, 32'h0);
    step(0, 3'd0, 0);
    rd(3'd5, v);
    chk("R4 selector rise", v, 32'h0000_FF00);
    check_state("R4");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule